// File: doc/BRIEF.md
# Fieldbus Slave Communication Watchdog

This block supervises the command traffic that a sensor/actuator bus slave receives. It asks for an unconditional slave reset when the master stops talking for too long. The frame decoder upstream reports every correctly received call with a one-cycle strobe and a call-type code. The watchdog looks only at the two call types that count as live cyclic traffic: the data exchange call and the parameter write call. Each of these restarts its silence timer. Every other call passes without touching the timer.

Supervision is gated by a configuration bit. It begins only after the first qualifying call since reset, since the last disable, or since the last timeout. An idle bus before that point is never treated as a fault. The silence window is set by two parameters, the clock rate in kHz and the window length in microseconds. A bench can therefore shorten it to a few cycles. At 125 MHz with a 40 ms window the count is 5,000,000 cycles. After it issues a reset pulse, the watchdog returns to the unarmed state.

Top module: `comm_watchdog`

## Requirements
- R1: While `srst` is high, and in the first cycle after it, `reset_req` is 0. A synchronous reset during a running window discards that window, and no pulse follows unless a new qualifying call arrives.
- R2: Whenever `wd_enable` is 0 at a clock edge, `reset_req` is 0 in the following cycle, and the watchdog returns to the unarmed state with its count cleared. Qualifying calls made while disabled do not arm it. After re-enabling, silence causes no pulse until a new qualifying call.
- R3: While unarmed, any length of silence produces no pulse. Valid calls of kinds other than 0 and 1 do not arm the watchdog.
- R4: `call_kind` 4'h0 (data exchange) and 4'h1 (parameter write) are the only codes that re-arm the timer. Valid calls with codes 4'h2 to 4'hF leave a running count unchanged, so the pulse time is unaffected.
- R5: If a qualifying call is sampled at clock edge k with `wd_enable` high, and no qualifying call, disable or reset follows, then `reset_req` is 1 in the cycle after edge k+T and 0 before it.
- R6: `reset_req` is a registered pulse that is never high for two consecutive cycles.
- R7: After a pulse the watchdog is unarmed, and further silence produces no second pulse.
- R8: A qualifying call sampled at the very edge where the window would expire re-arms the watchdog instead of firing it. The next pulse then comes T edges after that call.
- R9: T equals CLK_KHZ × WINDOW_US / 1000 clock cycles.
- R10: When `call_valid` is 0, `call_kind` has no effect, even when it carries 4'h0 or 4'h1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| wd_enable | input | 1 | Watchdog-active configuration bit |
| call_valid | input | 1 | One-cycle strobe for a correctly decoded master call |
| call_kind | input | KIND_W | Type code of the strobed call |
| reset_req | output | 1 | Registered one-cycle slave reset request |

## Verification
The hardest situation to reach from the ports is a contest on a single edge. A re-arming call, or a drop of the enable bit, lands on exactly the edge where the count would expire. The stimulus reaches it by timing the second call T−1 idle cycles after the first, which puts the strobe on the expiry edge itself. It then shows that the pulse moves a full window later (R8). A disable placed at the same offset must suppress the pulse completely (R2). Non-qualifying calls scattered inside a running window, and strobes of qualifying codes with the valid bit low, show that neither moves the pulse time.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

   // call type codes that count as live cyclic traffic
   localparam int unsigned CALL_XCHG     = 0;
   localparam int unsigned CALL_PARAM_WR = 1;

   // default re-arm mask: one bit per call code
   localparam logic [31:0] REARM_MASK_DEF = (32'd1 << CALL_XCHG) | (32'd1 << CALL_PARAM_WR);

   typedef enum logic {
      WD_IDLE  = 1'b0,
      WD_ARMED = 1'b1
   } wd_state_e;

   function automatic longint unsigned window_cycles(longint unsigned khz, longint unsigned us);
      return (khz * us) / 64'd1000;
   endfunction

endpackage

// File: rtl/cwd_rearm_filter.sv
module cwd_rearm_filter
   import cwd_pkg::*;
#(
   parameter int unsigned KIND_W      = 4,
   parameter logic [31:0] REARM_MASK  = REARM_MASK_DEF,
   parameter bit          MASK_LOOKUP = 1'b1
) (
   input  logic              call_valid,
   input  logic [KIND_W-1:0] call_kind,
   output logic              rearm
);

   generate
      if (MASK_LOOKUP) begin : g_mask
         // table driven: any code set may re-arm
         assign rearm = call_valid & REARM_MASK[call_kind];
      end else begin : g_cmp
         // fixed pair of comparators, no table
         assign rearm = call_valid &
                        ((call_kind == KIND_W'(CALL_XCHG)) |
                         (call_kind == KIND_W'(CALL_PARAM_WR)));
      end
   endgenerate

endmodule

// File: rtl/cwd_timer.sv
module cwd_timer #(
   parameter longint unsigned LIMIT      = 64'd2,
   parameter bit              COUNT_DOWN = 1'b0
) (
   input  logic clk,
   input  logic srst,
   input  logic clear,
   input  logic run,
   output logic expired
);

   localparam int unsigned CNT_W = (LIMIT > 64'd2) ? $clog2(LIMIT) : 1;
   localparam logic [CNT_W-1:0] TERM = CNT_W'(LIMIT - 64'd1);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   generate
      if (COUNT_DOWN) begin : g_down
         logic [CNT_W-1:0] cnt_q;
         assign expired = run & (cnt_q == '0);
         always_ff @(posedge clk) begin
            if (srst || clear) begin
               cnt_q <= TERM;
            end else if (run) begin
               cnt_q <= expired ? TERM : (cnt_q - ONE);
            end
         end
      end else begin : g_up
         logic [CNT_W-1:0] cnt_q;
         assign expired = run & (cnt_q == TERM);
         always_ff @(posedge clk) begin
            if (srst || clear) begin
               cnt_q <= '0;
            end else if (run) begin
               cnt_q <= expired ? '0 : (cnt_q + ONE);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cwd_arm_ctrl.sv
module cwd_arm_ctrl
   import cwd_pkg::*;
(
   input  logic clk,
   input  logic srst,
   input  logic enable,
   input  logic rearm,
   input  logic expired,
   output logic run,
   output logic clear,
   output logic reset_req
);

   wd_state_e state_q, state_d;
   logic      req_q;

   assign run   = (state_q == WD_ARMED) & enable & ~rearm;
   assign clear = ~enable | rearm;

   always_comb begin
      state_d = state_q;
      if (!enable) begin
         state_d = WD_IDLE;
      end else if (rearm) begin
         state_d = WD_ARMED;
      end else if (expired) begin
         state_d = WD_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (srst) begin
         state_q <= WD_IDLE;
         req_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         req_q   <= expired;
      end
   end

   assign reset_req = req_q;

endmodule

// File: rtl/comm_watchdog.sv
module comm_watchdog
   import cwd_pkg::*;
#(
   parameter int unsigned CLK_KHZ     = 125000,
   parameter int unsigned WINDOW_US   = 40000,
   parameter int unsigned KIND_W      = 4,
   parameter logic [31:0] REARM_MASK  = REARM_MASK_DEF,
   parameter bit          MASK_LOOKUP = 1'b1,
   parameter bit          COUNT_DOWN  = 1'b0
) (
   input  logic              clk,
   input  logic              srst,
   input  logic              wd_enable,
   input  logic              call_valid,
   input  logic [KIND_W-1:0] call_kind,
   output logic              reset_req
);

   localparam longint unsigned TIMEOUT_CYC = window_cycles(CLK_KHZ, WINDOW_US);

   generate
      if (TIMEOUT_CYC < 64'd2) begin : g_bad_window
         $error("comm_watchdog: window shorter than two cycles");
      end
      if (KIND_W < 1 || KIND_W > 5) begin : g_bad_kind
         $error("comm_watchdog: KIND_W must lie in 1..5");
      end
      if (REARM_MASK == 32'd0) begin : g_bad_mask
         $error("comm_watchdog: re-arm mask selects no call type");
      end
   endgenerate

   logic rearm;
   logic run;
   logic clear;
   logic expired;

   cwd_rearm_filter #(
      .KIND_W      (KIND_W),
      .REARM_MASK  (REARM_MASK),
      .MASK_LOOKUP (MASK_LOOKUP)
   ) i_filter (
      .call_valid (call_valid),
      .call_kind  (call_kind),
      .rearm      (rearm)
   );

   cwd_timer #(
      .LIMIT      (TIMEOUT_CYC),
      .COUNT_DOWN (COUNT_DOWN)
   ) i_timer (
      .clk     (clk),
      .srst    (srst),
      .clear   (clear),
      .run     (run),
      .expired (expired)
   );

   cwd_arm_ctrl i_ctrl (
      .clk       (clk),
      .srst      (srst),
      .enable    (wd_enable),
      .rearm     (rearm),
      .expired   (expired),
      .run       (run),
      .clear     (clear),
      .reset_req (reset_req)
   );

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker
   import cwd_pkg::*;
#(
   parameter int unsigned CLK_KHZ   = 125000,
   parameter int unsigned WINDOW_US = 40000,
   parameter int unsigned KIND_W    = 4
) (
   input logic              clk,
   input logic              srst,
   input logic              wd_enable,
   input logic              call_valid,
   input logic [KIND_W-1:0] call_kind,
   input logic              reset_req
);

   localparam longint unsigned LIM = window_cycles(CLK_KHZ, WINDOW_US);
   localparam int unsigned GW = $clog2(LIM + 64'd1);

   logic          qual;
   logic          sh_armed;
   logic [GW-1:0] sh_gap;
   logic          at_end;

   assign qual   = call_valid & ((call_kind == KIND_W'(CALL_XCHG)) |
                                 (call_kind == KIND_W'(CALL_PARAM_WR)));
   assign at_end = sh_armed & (sh_gap == GW'(LIM - 64'd1));

   // independent silence tracker
   always_ff @(posedge clk) begin
      if (srst || !wd_enable) begin
         sh_armed <= 1'b0;
         sh_gap   <= '0;
      end else if (qual) begin
         sh_armed <= 1'b1;
         sh_gap   <= '0;
      end else if (at_end) begin
         sh_armed <= 1'b0;
         sh_gap   <= '0;
      end else if (sh_armed) begin
         sh_gap <= sh_gap + GW'(1);
      end
   end

   // R6
   pulse_single_chk: assert property (@(posedge clk) disable iff (srst)
      reset_req |=> !reset_req);

   // R2
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (srst)
      !wd_enable |=> !reset_req);

   // R8
   rearm_wins_chk: assert property (@(posedge clk) disable iff (srst)
      (wd_enable && qual) |=> !reset_req);

   // R5
   expiry_fires_chk: assert property (@(posedge clk) disable iff (srst)
      (wd_enable && !qual && at_end) |=> reset_req);

   // R3
   no_unarmed_fire_chk: assert property (@(posedge clk) disable iff (srst)
      (!sh_armed || !wd_enable || qual || !at_end) |=> !reset_req);

endmodule

bind comm_watchdog cwd_checker #(
   .CLK_KHZ   (CLK_KHZ),
   .WINDOW_US (WINDOW_US),
   .KIND_W    (KIND_W)
) i_cwd_checker (
   .clk        (clk),
   .srst       (srst),
   .wd_enable  (wd_enable),
   .call_valid (call_valid),
   .call_kind  (call_kind),
   .reset_req  (reset_req)
);

// File: tb/test_comm_watchdog.sv
module test_comm_watchdog;

   localparam int unsigned CLK_KHZ   = 1;
   localparam int unsigned WINDOW_US = 20000;
   // R9: window in cycles from the requirement formula
   localparam int T = CLK_KHZ * WINDOW_US / 1000;

   logic       clk = 1'b0;
   logic       srst = 1'b1;
   logic       wd_enable = 1'b0;
   logic       call_valid = 1'b0;
   logic [3:0] call_kind = 4'h0;
   logic       reset_req;

   always #4 clk = ~clk;   // 125 MHz

   comm_watchdog #(
      .CLK_KHZ   (CLK_KHZ),
      .WINDOW_US (WINDOW_US),
      .KIND_W    (4)
   ) i_comm_watchdog (
      .clk        (clk),
      .srst       (srst),
      .wd_enable  (wd_enable),
      .call_valid (call_valid),
      .call_kind  (call_kind),
      .reset_req  (reset_req)
   );

   int    cyc = 0;
   int    exp_q[$];
   int    checks = 0;
   int    fails = 0;
   string tag = "R1";
   bit    mon_on = 1'b0;
   bit    last_pulse = 1'b0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expected pulse cycles and compares every cycle
   always @(negedge clk) begin
      if (mon_on) begin
         bit    want;
         string t;
         want = (exp_q.size() > 0) && (exp_q[0] == cyc);
         t = want ? "R5/R9" : (last_pulse ? "R6" : tag);
         if (want) void'(exp_q.pop_front());
         checks++;
         if (reset_req !== want) begin
            fails++;
            $display("FAIL %s cyc=%0d reset_req actual=%b expected=%b", t, cyc, reset_req, want);
         end
         last_pulse = want;
      end
   end

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk); #1;
         call_valid = 1'b0;
         call_kind  = 4'h0;
      end
   endtask

   // driver: one strobed call, expected pulse pushed to the scoreboard
   task automatic call(logic [3:0] kind);
      @(negedge clk); #1;
      call_valid = 1'b1;
      call_kind  = kind;
      if (wd_enable && (kind == 4'h0 || kind == 4'h1)) begin
         exp_q.delete();
         exp_q.push_back(cyc + 1 + T);
      end
   endtask

   task automatic kind_only(logic [3:0] kind);
      @(negedge clk); #1;
      call_valid = 1'b0;
      call_kind  = kind;
   endtask

   task automatic set_enable(logic v);
      @(negedge clk); #1;
      call_valid = 1'b0;
      wd_enable  = v;
      if (!v) exp_q.delete();
   endtask

   task automatic pulse_reset();
      @(negedge clk); #1;
      call_valid = 1'b0;
      srst = 1'b1;
      exp_q.delete();
      @(negedge clk); #1;
      srst = 1'b0;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (reset_req !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset_req in reset actual=%b expected=0", reset_req);
      end
      mon_on = 1'b1;
      #1 srst = 1'b0;

      // R3: silence and other calls while unarmed
      tag = "R3";
      set_enable(1'b1);
      idle(3 * T);
      call(4'h2); idle(4); call(4'h5); idle(7); call(4'hF);
      idle(2 * T);

      // R10: qualifying codes without the strobe
      tag = "R10";
      kind_only(4'h0); kind_only(4'h1); kind_only(4'h0);
      idle(2 * T);

      // R5, R6, R7: plain timeout then lasting silence
      tag = "R7";
      call(4'h0);
      idle(3 * T);

      // R4: non-qualifying calls inside a running window
      tag = "R4";
      call(4'h1); idle(5); call(4'h3); idle(4); call(4'h9); call(4'hE);
      idle(2 * T);

      // R4: re-arm by a parameter write mid-window
      call(4'h0); idle(8); call(4'h1);
      idle(2 * T);

      // R8: re-arm on the exact expiry edge
      tag = "R8";
      call(4'h0); idle(T - 1); call(4'h1);
      idle(2 * T);

      // R2: disable mid-window, calls while disabled, re-enable
      tag = "R2";
      call(4'h0); idle(10);
      set_enable(1'b0);
      idle(2 * T);
      call(4'h0); idle(3); call(4'h1);
      idle(2 * T);
      set_enable(1'b1);
      idle(2 * T);

      // R2: disable landing on the expiry edge
      call(4'h1); idle(T - 1);
      set_enable(1'b0);
      idle(T);
      set_enable(1'b1);

      // R1: reset during a running window
      tag = "R1";
      call(4'h0); idle(5);
      pulse_reset();
      idle(2 * T);

      // R5: operation resumes after reset
      tag = "R7";
      call(4'h1);
      idle(2 * T);

      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R5 pending pulses actual=%0d expected=0", exp_q.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule